// File: doc/BRIEF.md
# Host-to-Controller Word Mailbox

This block sits between a host processor and an embedded controller and carries 32-bit words in both directions. It keeps two word stores: an outbound store filled by the host and drained by the controller, and an inbound store filled by the controller and drained by the host. Each store has a write index and a read index. Both indices count words since the last clear and never wrap, so a store becomes full once its write index reaches the configured depth. A full store stays full until the host clears it, even after words have been drained.

The host reaches the block through a four-address register port. Each access is one cycle, and read data appears one cycle later. The port exposes the host control/status word, a read-only view of the controller's control/status word, a transmit window and a receive window.

Doorbells pass attention in both directions. A host write with the generate bit set raises a pending interrupt toward the controller. A ring pulse from the controller sets a status bit that can interrupt the host. The host can also clear both stores and drop its ready flag by writing the reset bit, then announce readiness again with a later write.

On the controller side the port is simpler. It has a push strobe with data, a pop strobe with the head word shown combinationally, a count of words waiting, a ready input, a ring input and an acknowledge input.

Top module: `mb_mailbox`

## Requirements
- R1: After reset the host control word (address 0) reads as depth in bits [31:24] with every other bit 0. The controller view (address 1) reads depth in [31:24] and interrupt-enable (bit 0) as 1, with all else 0 while the ready input is low. Both interrupt outputs are low.
- R2: A host write to address 2 appends the word to the outbound store and raises the outbound write index (host word bits [23:16]) by one. The controller pops the words in write order from `ctl_pop_data_o`, and each pop raises the outbound read index (host word bits [15:8]) by one.
- R3: A host write to address 2 while the outbound write index equals the depth is dropped and sets the sticky overflow bit (bit 5 of the host word). Draining a word does not make room again before a clear.
- R4: A host read of address 3 returns the oldest unread inbound word and raises the inbound read index (controller view bits [15:8]) by one. A read of address 3 with nothing waiting returns 0 and moves no index. Words waiting equal write index minus read index.
- R5: A host control write with bit 2 (generate) set latches `ctl_irq_o` high from the next cycle until `ctl_ack_i`. Bit 2 clears itself after one cycle, so a later read shows it as 0.
- R6: A `ctl_ring_i` pulse sets host status bit 1. `host_irq_o` is status AND enable (bit 0). Writing 1 to bit 1 clears the status bit; writing 0 to bit 1 leaves it unchanged.
- R7: A host control write with bit 4 (reset) set empties both stores at once and clears both overflow bits. It forces the host ready bit (bit 3) to 0. The stores stay empty, and transmit writes are dropped, while the reset bit stays 1. A later write with reset 0 and ready 1 sets ready again.
- R8: The controller view shows the ready input in bit 3, the pending host doorbell in bit 1, the host reset bit in bit 4, and the inbound indices and overflow in the same field positions as the host word.
- R9: A controller push while the inbound write index equals the depth is dropped and sets the inbound overflow bit (controller view bit 5).
- R10: A controller pop with no outbound word waiting is ignored and leaves the outbound read index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | 2 | Host register address: 0 control, 1 controller view, 2 transmit, 3 receive |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid the cycle after the read strobe |
| host_irq_o | output | 1 | Interrupt to the host |
| ctl_irq_o | output | 1 | Pending host doorbell to the controller |
| ctl_ready_i | input | 1 | Controller ready flag |
| ctl_ring_i | input | 1 | Controller doorbell pulse toward the host |
| ctl_ack_i | input | 1 | Controller acknowledge of the host doorbell |
| ctl_pop_i | input | 1 | Controller pop of the outbound store |
| ctl_pop_data_o | output | 32 | Head word of the outbound store, 0 when empty |
| ctl_avail_o | output | $clog2(DEPTH+1) | Outbound words waiting |
| ctl_push_i | input | 1 | Controller push into the inbound store |
| ctl_push_data_i | input | 32 | Word pushed by the controller |

## Verification
The hardest state to reach is a full outbound store that has been partly drained. The write index sits at the depth, the read index is above zero, and a further write must still be dropped instead of reusing the freed slot. The stimulus writes exactly depth words, writes one more, pops one from the controller side and writes again. It then reads the control word to confirm the indices and the sticky overflow bit. A transmit write placed inside a held reset shows at the ports that the clear outranks the append.

// File: rtl/mb_pkg.sv
package mb_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 8;

  typedef enum logic [1:0] {
    A_HCSR  = 2'd0,
    A_CVIEW = 2'd1,
    A_TXWIN = 2'd2,
    A_RXWIN = 2'd3
  } mb_addr_e;

  localparam int unsigned B_IE  = 0;
  localparam int unsigned B_IS  = 1;
  localparam int unsigned B_IG  = 2;
  localparam int unsigned B_RDY = 3;
  localparam int unsigned B_RST = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] depth;
    logic [FIELD_W-1:0] wptr;
    logic [FIELD_W-1:0] rptr;
    logic [1:0]         rsvd;
    logic               ovf;
    logic               rst;
    logic               rdy;
    logic               ig;
    logic               is;
    logic               ie;
  } mb_csr_t;

endpackage

// File: rtl/mb_fifo.sv
module mb_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                pop_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   wptr_o,
  output logic [$clog2(DEPTH+1)-1:0]   rptr_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         ovf_o
);

  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic          ovf_q, ovf_d;
  logic          we;
  logic          full, empty;

  assign full  = (wptr_q == PW'(DEPTH));
  assign empty = (rptr_q == wptr_q);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    ovf_d  = ovf_q;
    we     = 1'b0;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      ovf_d  = 1'b0;
    end else begin
      if (push_i) begin
        if (full) begin
          ovf_d = 1'b1;
        end else begin
          wptr_d = wptr_q + 1'b1;
          we     = 1'b1;
        end
      end
      if (pop_i && !empty) begin
        rptr_d = rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wptr_q[AW-1:0]] <= push_data_i;
    end
  end

  assign pop_data_o = empty ? '0 : mem[rptr_q[AW-1:0]];
  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign count_o    = wptr_q - rptr_q;
  assign ovf_o      = ovf_q;

endmodule

// File: rtl/mb_doorbell.sv
module mb_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr_i,
  input  logic wd_ie_i,
  input  logic wd_is_i,
  input  logic wd_ig_i,
  input  logic peer_ring_i,
  input  logic peer_ack_i,
  output logic ie_o,
  output logic is_o,
  output logic ig_o,
  output logic pend_o,
  output logic host_irq_o
);

  logic ie_q, ie_d;
  logic is_q, is_d;
  logic ig_q, ig_d;
  logic pend_q, pend_d;

  always_comb begin
    ie_d   = csr_wr_i ? wd_ie_i : ie_q;
    is_d   = is_q;
    if (csr_wr_i && wd_is_i) is_d = 1'b0;
    if (peer_ring_i)         is_d = 1'b1;
    ig_d   = csr_wr_i && wd_ig_i;
    pend_d = pend_q;
    if (peer_ack_i)          pend_d = 1'b0;
    if (csr_wr_i && wd_ig_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      is_q   <= 1'b0;
      ig_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      is_q   <= is_d;
      ig_q   <= ig_d;
      pend_q <= pend_d;
    end
  end

  assign ie_o       = ie_q;
  assign is_o       = is_q;
  assign ig_o       = ig_q;
  assign pend_o     = pend_q;
  assign host_irq_o = is_q && ie_q;

endmodule

// File: rtl/mb_mailbox.sv
module mb_mailbox
  import mb_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 hb_addr,
  input  logic                       hb_wr,
  input  logic                       hb_rd,
  input  logic [31:0]                hb_wdata,
  output logic [31:0]                hb_rdata,
  output logic                       host_irq_o,
  output logic                       ctl_irq_o,
  input  logic                       ctl_ready_i,
  input  logic                       ctl_ring_i,
  input  logic                       ctl_ack_i,
  input  logic                       ctl_pop_i,
  output logic [31:0]                ctl_pop_data_o,
  output logic [$clog2(DEPTH+1)-1:0] ctl_avail_o,
  input  logic                       ctl_push_i,
  input  logic [31:0]                ctl_push_data_i
);

  localparam int unsigned PW = $clog2(DEPTH + 1);

  logic          hcsr_wr, tx_push, rx_pop;
  logic          fifo_clr;
  logic          rdy_q, rdy_d, rst_q, rst_d;
  logic [31:0]   rdata_q, rdata_d;
  logic [PW-1:0] h2c_wptr, h2c_rptr, h2c_cnt;
  logic [PW-1:0] c2h_wptr, c2h_rptr, c2h_cnt;
  logic          h2c_ovf, c2h_ovf;
  logic [31:0]   c2h_head;
  logic          ie_q, is_q, ig_q, pend_q;
  mb_csr_t       hcsr, cview;

  assign hcsr_wr  = hb_wr && (hb_addr == A_HCSR);
  assign tx_push  = hb_wr && (hb_addr == A_TXWIN);
  assign rx_pop   = hb_rd && (hb_addr == A_RXWIN);
  assign fifo_clr = rst_q || (hcsr_wr && hb_wdata[B_RST]);

  mb_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_h2c (
    .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr),
    .push_i(tx_push), .push_data_i(hb_wdata),
    .pop_i(ctl_pop_i), .pop_data_o(ctl_pop_data_o),
    .wptr_o(h2c_wptr), .rptr_o(h2c_rptr), .count_o(h2c_cnt), .ovf_o(h2c_ovf)
  );

  mb_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_c2h (
    .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr),
    .push_i(ctl_push_i), .push_data_i(ctl_push_data_i),
    .pop_i(rx_pop), .pop_data_o(c2h_head),
    .wptr_o(c2h_wptr), .rptr_o(c2h_rptr), .count_o(c2h_cnt), .ovf_o(c2h_ovf)
  );

  mb_doorbell u_bell (
    .clk(clk), .rst_n(rst_n), .csr_wr_i(hcsr_wr),
    .wd_ie_i(hb_wdata[B_IE]), .wd_is_i(hb_wdata[B_IS]), .wd_ig_i(hb_wdata[B_IG]),
    .peer_ring_i(ctl_ring_i), .peer_ack_i(ctl_ack_i),
    .ie_o(ie_q), .is_o(is_q), .ig_o(ig_q), .pend_o(pend_q),
    .host_irq_o(host_irq_o)
  );

  always_comb begin
    hcsr       = '0;
    hcsr.depth = FIELD_W'(DEPTH);
    hcsr.wptr  = FIELD_W'(h2c_wptr);
    hcsr.rptr  = FIELD_W'(h2c_rptr);
    hcsr.ovf   = h2c_ovf;
    hcsr.rst   = rst_q;
    hcsr.rdy   = rdy_q;
    hcsr.ig    = ig_q;
    hcsr.is    = is_q;
    hcsr.ie    = ie_q;

    cview       = '0;
    cview.depth = FIELD_W'(DEPTH);
    cview.wptr  = FIELD_W'(c2h_wptr);
    cview.rptr  = FIELD_W'(c2h_rptr);
    cview.ovf   = c2h_ovf;
    cview.rst   = rst_q;
    cview.rdy   = ctl_ready_i;
    cview.is    = pend_q;
    cview.ie    = 1'b1;
  end

  always_comb begin
    rdy_d   = rdy_q;
    rst_d   = rst_q;
    rdata_d = rdata_q;
    if (hcsr_wr) begin
      rst_d = hb_wdata[B_RST];
      rdy_d = hb_wdata[B_RDY] && !hb_wdata[B_RST];
    end
    if (hb_rd) begin
      unique case (mb_addr_e'(hb_addr))
        A_HCSR:  rdata_d = hcsr;
        A_CVIEW: rdata_d = cview;
        A_RXWIN: rdata_d = c2h_head;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      rst_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q   <= rdy_d;
      rst_q   <= rst_d;
      rdata_q <= rdata_d;
    end
  end

  assign hb_rdata    = rdata_q;
  assign ctl_irq_o   = pend_q;
  assign ctl_avail_o = h2c_cnt;

endmodule

// File: rtl/mb_mailbox_chk.sv
module mb_mailbox_chk
  import mb_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hb_wr,
  input logic [1:0]                 hb_addr,
  input logic [31:0]                hb_wdata,
  input logic                       fifo_clr,
  input logic                       rst_q,
  input logic                       ig_q,
  input logic [$clog2(DEPTH+1)-1:0] h2c_wptr,
  input logic [$clog2(DEPTH+1)-1:0] c2h_wptr,
  input logic [$clog2(DEPTH+1)-1:0] c2h_rptr
);

  localparam int unsigned PW = $clog2(DEPTH + 1);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2c_wptr <= PW'(DEPTH));

  // R2
  tx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_wr && hb_addr == A_TXWIN && !fifo_clr && h2c_wptr < PW'(DEPTH))
      |=> (h2c_wptr == $past(h2c_wptr) + 1'b1));

  // R7
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (h2c_wptr == '0 && c2h_wptr == '0));

  // R5
  ig_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ig_q && !(hb_wr && hb_addr == A_HCSR && hb_wdata[B_IG])) |=> !ig_q);

  // R4
  rx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c2h_rptr <= c2h_wptr);

endmodule

bind mb_mailbox mb_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr),
  .hb_wdata(hb_wdata), .fifo_clr(fifo_clr), .rst_q(rst_q), .ig_q(ig_q),
  .h2c_wptr(h2c_wptr), .c2h_wptr(c2h_wptr), .c2h_rptr(c2h_rptr)
);

// File: tb/mb_mailbox_test.sv
module mb_mailbox_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int PW         = $clog2(DEPTH + 1);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CPOP = 2'd2, OP_CPUSH = 2'd3;
  localparam int NVEC = 15;

  function automatic logic [31:0] csr(int wp, int rp, bit ovf, bit rs, bit rdy,
                                      bit ig, bit is, bit ie);
    return {8'(DEPTH), 8'(wp), 8'(rp), 2'b00, ovf, rs, rdy, ig, is, ie};
  endfunction

  // vector: {req[3:0], op[1:0], addr[1:0], data[31:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd1,  OP_RD,    2'd0, 32'h2000_0000},  // R1 host word after reset
    {4'd1,  OP_RD,    2'd1, 32'h2000_0001},  // R1 controller view after reset
    {4'd2,  OP_WR,    2'd2, 32'h0000_00A1},  // R2
    {4'd2,  OP_WR,    2'd2, 32'h0000_00B2},  // R2
    {4'd2,  OP_RD,    2'd0, 32'h2002_0000},  // R2 write index 2
    {4'd2,  OP_CPOP,  2'd0, 32'h0000_00A1},  // R2 order
    {4'd2,  OP_CPOP,  2'd0, 32'h0000_00B2},  // R2 order
    {4'd2,  OP_RD,    2'd0, 32'h2002_0200},  // R2 read index 2
    {4'd4,  OP_CPUSH, 2'd0, 32'h0000_00C3},  // R4
    {4'd4,  OP_CPUSH, 2'd0, 32'h0000_00D4},  // R4
    {4'd8,  OP_RD,    2'd1, 32'h2002_0001},  // R8 inbound indices
    {4'd4,  OP_RD,    2'd3, 32'h0000_00C3},  // R4
    {4'd4,  OP_RD,    2'd3, 32'h0000_00D4},  // R4
    {4'd4,  OP_RD,    2'd3, 32'h0000_0000},  // R4 empty read
    {4'd4,  OP_RD,    2'd1, 32'h2002_0201}   // R4 no index move
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    hb_addr;
  logic          hb_wr, hb_rd;
  logic [31:0]   hb_wdata, hb_rdata;
  logic          host_irq_o, ctl_irq_o;
  logic          ctl_ready_i, ctl_ring_i, ctl_ack_i;
  logic          ctl_pop_i, ctl_push_i;
  logic [31:0]   ctl_pop_data_o, ctl_push_data_i;
  logic [PW-1:0] ctl_avail_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mb_mailbox #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr), .hb_rd(hb_rd),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .host_irq_o(host_irq_o),
    .ctl_irq_o(ctl_irq_o), .ctl_ready_i(ctl_ready_i), .ctl_ring_i(ctl_ring_i),
    .ctl_ack_i(ctl_ack_i), .ctl_pop_i(ctl_pop_i), .ctl_pop_data_o(ctl_pop_data_o),
    .ctl_avail_o(ctl_avail_o), .ctl_push_i(ctl_push_i),
    .ctl_push_data_i(ctl_push_data_i)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk); hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk); hb_wr = 1'b0;
  endtask

  task automatic hread(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); hb_addr = a; hb_rd = 1'b1;
    @(negedge clk); hb_rd = 1'b0; d = hb_rdata;
  endtask

  task automatic cpop(output logic [31:0] d);
    @(negedge clk); d = ctl_pop_data_o; ctl_pop_i = 1'b1;
    @(negedge clk); ctl_pop_i = 1'b0;
  endtask

  task automatic cpush(logic [31:0] d);
    @(negedge clk); ctl_push_data_i = d; ctl_push_i = 1'b1;
    @(negedge clk); ctl_push_i = 1'b0;
  endtask

  task automatic pulse_ring();
    @(negedge clk); ctl_ring_i = 1'b1;
    @(negedge clk); ctl_ring_i = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ctl_ack_i = 1'b1;
    @(negedge clk); ctl_ack_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    string tag;
    rst_n = 1'b0; hb_addr = '0; hb_wr = 1'b0; hb_rd = 1'b0; hb_wdata = '0;
    ctl_ready_i = 1'b0; ctl_ring_i = 1'b0; ctl_ack_i = 1'b0;
    ctl_pop_i = 1'b0; ctl_push_i = 1'b0; ctl_push_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 irq outputs", {30'd0, host_irq_o, ctl_irq_o}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[39:36], i);
      unique case (v[35:34])
        OP_WR:    hwrite(v[33:32], v[31:0]);
        OP_RD:    begin hread(v[33:32], d); check(tag, d, v[31:0]); end
        OP_CPOP:  begin cpop(d); check(tag, d, v[31:0]); end
        default:  cpush(v[31:0]);
      endcase
    end

    // R10 pop with nothing waiting
    check("R10 avail", 32'(ctl_avail_o), 32'd0);
    cpop(d);
    hread(2'd0, d); check("R10 index held", d, csr(2, 2, 0, 0, 0, 0, 0, 0));

    // R6 controller ring, enable, write-1-to-clear
    pulse_ring();
    check("R6 irq masked", 32'(host_irq_o), 32'd0);
    hread(2'd0, d); check("R6 status set", d, csr(2, 2, 0, 0, 0, 0, 1, 0));
    hwrite(2'd0, 32'h1);
    check("R6 irq enabled", 32'(host_irq_o), 32'd1);
    hwrite(2'd0, 32'h1);
    check("R6 write 0 ignored", 32'(host_irq_o), 32'd1);
    hwrite(2'd0, 32'h3);
    check("R6 w1c", 32'(host_irq_o), 32'd0);

    // R5 host doorbell
    hwrite(2'd0, 32'h5);
    check("R5 ctl irq", 32'(ctl_irq_o), 32'd1);
    hread(2'd0, d); check("R5 ig self clear", d, csr(2, 2, 0, 0, 0, 0, 0, 1));
    hread(2'd1, d); check("R5 pending in view", d, csr(2, 2, 0, 0, 0, 0, 1, 1));
    check("R5 irq held", 32'(ctl_irq_o), 32'd1);
    pulse_ack();
    check("R5 ack", 32'(ctl_irq_o), 32'd0);

    // R8 ready input mirrored
    ctl_ready_i = 1'b1;
    hread(2'd1, d); check("R8 ready view", d, csr(2, 2, 0, 0, 1, 0, 0, 1));

    // R7 clear handshake, transmit write during held reset
    hwrite(2'd0, 32'h15);
    hwrite(2'd2, 32'hEE);
    hread(2'd0, d); check("R7 host cleared", d, csr(0, 0, 0, 1, 0, 0, 0, 1));
    hread(2'd1, d); check("R7 view cleared", d, csr(0, 0, 0, 1, 1, 0, 1, 1));
    pulse_ack();
    hwrite(2'd0, 32'h0D);
    pulse_ack();
    hread(2'd0, d); check("R7 ready again", d, csr(0, 0, 0, 0, 1, 0, 0, 1));
    check("R7 write dropped", 32'(ctl_avail_o), 32'd0);

    // R3 full outbound store, no reuse after drain
    for (int i = 0; i < DEPTH; i++) hwrite(2'd2, 32'h100 + i);
    hread(2'd0, d); check("R3 full", d, csr(32, 0, 0, 0, 1, 0, 0, 1));
    hwrite(2'd2, 32'hBAD);
    hread(2'd0, d); check("R3 overflow", d, csr(32, 0, 1, 0, 1, 0, 0, 1));
    cpop(d); check("R3 head", d, 32'h100);
    hwrite(2'd2, 32'hBAD2);
    hread(2'd0, d); check("R3 no wrap", d, csr(32, 1, 1, 0, 1, 0, 0, 1));
    check("R3 avail", 32'(ctl_avail_o), 32'd31);

    // R9 inbound overflow
    for (int i = 0; i < DEPTH; i++) cpush(32'h200 + i);
    cpush(32'hBAD3);
    hread(2'd1, d); check("R9 overflow", d, csr(32, 0, 1, 0, 1, 0, 0, 1));
    hread(2'd3, d); check("R9 head kept", d, 32'h200);

    // R7 clear drops overflow bits
    hwrite(2'd0, 32'h11);
    hwrite(2'd0, 32'h09);
    hread(2'd0, d); check("R7 host ovf clear", d, csr(0, 0, 0, 0, 1, 0, 0, 1));
    hread(2'd1, d); check("R7 view ovf clear", d, csr(0, 0, 0, 0, 1, 0, 0, 1));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule